// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is one channel of a timer/PWM unit. Software sets up the next period in two buffer registers, a count buffer and a compare buffer. It then uses a four-bit control field to copy those buffers into the live counter and to start the channel. The live counter counts down once per `tick_en` pulse, which comes from a prescaler outside this block. When the counter reaches zero, the channel either reloads from the buffers and keeps running, or, with auto-reload cleared, finishes that period and stops.

The output goes active when the decremented count equals the live compare value. It stays active until the next reload. An invert control bit flips the pin level. A stopped channel drives its inactive level. Several channels share one control word, so each channel decodes only its own four-bit field at a fixed position.

This block has no streaming interface. Register writes are single-cycle strobes. The block accepts one on every cycle, with no back-pressure and no read path. The live counter is visible on `count_o`.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After reset, `count_o` is 0, `running` is 0 and `pwm_out` is 0.
- R2: While the manual-update bit (bit 1 of the channel field) is 1, the live counter takes the count buffer on every clock. The live compare register takes the compare buffer in the same way. The counter does not count while this bit is 1, even with start set.
- R3: Until a manual update has taken place since reset, the start bit (bit 0 of the field) has no effect: `count_o` stays 0 and `running` stays 0.
- R4: With start and auto-reload (bit 3) set, each tick lowers the counter by one. A tick at count 0 reloads the count buffer. A buffer value of N-1 therefore gives a period of N ticks.
- R5: The raw level is 0 after every load. It becomes 1 on the tick whose decremented count equals the compare value, and it stays 1 until the next load. A compare value not below the loaded count never sets it.
- R6: `pwm_out` equals the raw level XOR the invert bit (bit 2 of the field) while running. While stopped, `pwm_out` equals the invert bit.
- R7: If auto-reload is 0, the channel stops on the tick at count 0. It then holds the count at 0 with `running` low until the next manual update.
- R8: Buffer writes made while running change nothing until the next reload at terminal count.
- R9: The control word is written at address 0x08. Channel CHAN uses bits [3:0] if CHAN is 0, and bits [4*(CHAN+1)+3 : 4*(CHAN+1)] otherwise. The count buffer is at 0x0C+12*CHAN and the compare buffer at 0x10+12*CHAN. Every other bit of the control word is ignored.
- R10: In a cycle without `tick_en`, the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| pwm_out | output | 1 | PWM pin level |
| running | output | 1 | Channel is counting |
| count_o | output | CNT_W | Live counter value |

## Verification
The assertions assume that `tick_en` and the register strobe are synchronous single-cycle inputs. They also assume that the control field is always written whole, so the start, manual-update and auto-reload bits change together.

The stimulus changes the buffers and the control field only at falling clock edges. It leaves manual update set for exactly one load cycle before a start. It varies the tick spacing so that counting without a tick is exercised, while every expected count stays a simple function of the number of ticks applied.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  // Per-channel control field; bit order is decoded by the channel logic.
  typedef struct packed {
    logic autoreload;  // bit 3
    logic invert;      // bit 2
    logic manual;      // bit 1
    logic start;       // bit 0
  } ctl_t;

  localparam int CTL_ADDR = 8'h08;

  function automatic int slot_lsb(input int ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction

  function automatic int cnt_addr(input int ch);
    return 12 + 12 * ch;
  endfunction

  function automatic int cmp_addr(input int ch);
    return 16 + 12 * ch;
  endfunction

endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int CHAN   = 1,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_buf,
  output logic [CNT_W-1:0]  cmp_buf,
  output ctl_t              ctl
);

  localparam int SLOT = slot_lsb(CHAN);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(cnt_addr(CHAN));
  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(cmp_addr(CHAN));

  logic hit_ctl, hit_cnt, hit_cmp;
  assign hit_ctl = wr_en && (wr_addr == A_CTL);
  assign hit_cnt = wr_en && (wr_addr == A_CNT);
  assign hit_cmp = wr_en && (wr_addr == A_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_buf <= '0;
      cmp_buf <= '0;
      ctl     <= '0;
    end else begin
      if (hit_cnt) cnt_buf <= wr_data[CNT_W-1:0];
      if (hit_cmp) cmp_buf <= wr_data[CNT_W-1:0];
      if (hit_ctl) ctl     <= ctl_t'(wr_data[SLOT +: 4]);
    end
  end

endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  ctl_t             ctl,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             run,
  output logic             load_evt,
  output logic             dec_evt,
  output logic             stop_evt
);

  logic loaded, halted, at_zero, step;

  assign run      = ctl.start && loaded && !halted && !ctl.manual;
  assign at_zero  = (cnt_q == '0);
  assign step     = run && tick_en;
  assign cnt_dec  = cnt_q - 1'b1;
  assign dec_evt  = step && !at_zero;
  assign stop_evt = step && at_zero && !ctl.autoreload;
  assign load_evt = ctl.manual || (step && at_zero && ctl.autoreload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      loaded <= 1'b0;
      halted <= 1'b0;
    end else if (ctl.manual) begin
      cnt_q  <= cnt_buf;
      cmp_q  <= cmp_buf;
      loaded <= 1'b1;
      halted <= 1'b0;
    end else if (load_evt) begin
      cnt_q <= cnt_buf;
      cmp_q <= cmp_buf;
    end else if (stop_evt) begin
      halted <= 1'b1;
    end else if (dec_evt) begin
      cnt_q <= cnt_dec;
    end
  end

  p_manual_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.manual |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf)));

  p_unloaded_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded && !ctl.manual) |=> (cnt_q == '0) && !run);

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && cnt_q == '0 && ctl.autoreload) |=> cnt_q == $past(cnt_buf));

  p_finish_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && cnt_q == '0 && !ctl.autoreload) |=> !run && cnt_q == '0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick_en) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_dbuf_outstage.sv
module pwm_dbuf_outstage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             invert,
  input  logic             load_evt,
  input  logic             stop_evt,
  input  logic             dec_evt,
  input  logic [CNT_W-1:0] cnt_dec,
  input  logic [CNT_W-1:0] cmp_q,
  output logic             pwm_out
);

  logic lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           lvl <= 1'b0;
    else if (load_evt || stop_evt)        lvl <= 1'b0;
    else if (dec_evt && cnt_dec == cmp_q) lvl <= 1'b1;
  end

  assign pwm_out = (run && lvl) ^ invert;

  p_low_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !lvl);

  p_stopped_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !lvl);

endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int CHAN   = 1,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out,
  output logic              running,
  output logic [CNT_W-1:0]  count_o
);

  ctl_t             ctl;
  logic [CNT_W-1:0] cnt_buf, cmp_buf, cnt_q, cmp_q, cnt_dec;
  logic             run, load_evt, dec_evt, stop_evt;

  pwm_dbuf_regs #(.CHAN(CHAN), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_buf(cnt_buf), .cmp_buf(cmp_buf), .ctl(ctl)
  );

  pwm_dbuf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl(ctl),
    .cnt_buf(cnt_buf), .cmp_buf(cmp_buf), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .cnt_dec(cnt_dec), .run(run), .load_evt(load_evt), .dec_evt(dec_evt),
    .stop_evt(stop_evt)
  );

  pwm_dbuf_outstage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .run(run), .invert(ctl.invert),
    .load_evt(load_evt), .stop_evt(stop_evt), .dec_evt(dec_evt),
    .cnt_dec(cnt_dec), .cmp_q(cmp_q), .pwm_out(pwm_out)
  );

  assign running = run;
  assign count_o = cnt_q;

endmodule

// File: tb/tb_pwm_dbuf_chan.sv
module tb_pwm_dbuf_chan;

  localparam int CNT_W = 16;
  localparam logic [7:0] A_CTL = 8'h08;
  localparam logic [7:0] A_CNT = 8'h18;  // channel 1 count buffer
  localparam logic [7:0] A_CMP = 8'h1C;  // channel 1 compare buffer
  localparam int SH = 8;                  // channel 1 field position
  localparam int B_START = 1, B_MAN = 2, B_INV = 4, B_AR = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic pwm_out, running;
  logic [CNT_W-1:0] count_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwm_dbuf_chan #(.CHAN(1), .CNT_W(CNT_W), .ADDR_W(8), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .running(running), .count_o(count_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_cfg(input int n, input int cm, input int iv);
    tick_en = 1'b0;
    wr(A_CNT, n - 1);
    wr(A_CMP, cm);
    wr(A_CTL, (B_MAN | (iv ? B_INV : 0)) << SH);
    wr(A_CTL, (B_START | B_AR | (iv ? B_INV : 0)) << SH);
  endtask

  task automatic run_seq(input int n, input int cm, input int iv, input int tp, input int cyc);
    int k = 0;
    for (int i = 0; i < cyc; i++) begin
      int c = (n - 1) - (k % n);
      int raw = (c <= cm && cm < n - 1) ? 1 : 0;
      bit t = ((i % tp) == 0);
      chk("R4/R10 count", int'(count_o), c);
      chk("R5/R6 level", int'(pwm_out), raw ^ iv);
      chk("R4 running", int'(running), 1);
      tick_en = t;
      @(negedge clk);
      if (t) k++;
    end
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", int'(count_o), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 pwm", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: bits outside this channel's field are ignored
    wr(A_CNT, 7);
    wr(A_CMP, 2);
    wr(A_CTL, 32'hFFFF_F0FF);
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 count", int'(count_o), 0);
    chk("R9 running", int'(running), 0);
    chk("R9 pwm", int'(pwm_out), 0);

    // R3: start ignored before any manual update
    wr(A_CTL, (B_START | B_AR) << SH);
    repeat (5) @(negedge clk);
    chk("R3 count", int'(count_o), 0);
    chk("R3 running", int'(running), 0);
    tick_en = 1'b0;
    wr(A_CTL, 0);

    // R2: manual update while stopped loads, counter frozen
    wr(A_CNT, 11);
    wr(A_CTL, B_MAN << SH);
    @(negedge clk);
    chk("R2 load", int'(count_o), 11);
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 frozen", int'(count_o), 11);
    chk("R2 running", int'(running), 0);
    tick_en = 1'b0;
    wr(A_CTL, 0);

    // R4 R5 R6 R10 sweep
    for (int n = 1; n <= 8; n++)
      for (int cm = 0; cm <= 9; cm++)
        for (int iv = 0; iv < 2; iv++) begin
          int tp = (cm % 3) + 1;
          start_cfg(n, cm, iv);
          run_seq(n, cm, iv, tp, tp * (2 * n + 1) + 2);
          wr(A_CTL, 0);
        end

    // R7: clearing auto-reload finishes the period then stops
    start_cfg(5, 1, 0);
    chk("R7 t0", int'(count_o), 4);
    tick_en = 1'b1;
    @(negedge clk);
    chk("R7 t1", int'(count_o), 3);
    wr_en = 1'b1; wr_addr = A_CTL; wr_data = B_START << SH;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 t2", int'(count_o), 2);
    @(negedge clk);
    chk("R7 t3", int'(count_o), 1);
    @(negedge clk);
    chk("R7 t4 count", int'(count_o), 0);
    chk("R7 t4 running", int'(running), 1);
    chk("R7 t4 pwm", int'(pwm_out), 1);
    @(negedge clk);
    chk("R7 stopped", int'(running), 0);
    chk("R7 pwm idle", int'(pwm_out), 0);
    repeat (4) @(negedge clk);
    chk("R7 held count", int'(count_o), 0);
    // R6: stopped output follows invert
    wr(A_CTL, (B_START | B_INV) << SH);
    chk("R6 idle inverted", int'(pwm_out), 1);
    chk("R6 still stopped", int'(running), 0);
    tick_en = 1'b0;
    wr(A_CTL, 0);

    // R8: buffer write mid-period applies at reload
    start_cfg(4, 9, 0);
    chk("R8 t0", int'(count_o), 3);
    tick_en = 1'b1;
    wr(A_CNT, 6);
    chk("R8 t1", int'(count_o), 2);
    @(negedge clk);
    chk("R8 t2", int'(count_o), 1);
    @(negedge clk);
    chk("R8 t3", int'(count_o), 0);
    @(negedge clk);
    chk("R8 reload new", int'(count_o), 6);
    @(negedge clk);
    chk("R8 t5", int'(count_o), 5);
    tick_en = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule